// File: doc/BRIEF.md
# Codec Control Register Bank

This block holds the 16-bit control and status words that a link controller reaches by index through the command and status slots of an audio codec link. A write strobe with an index and a data word updates one register at the clock edge. A separate read index selects the word returned on the read port, with no clock delay. The decoded fields (volume and gain levels, mutes, 3D depth, converter sample rates, and whether the codec drives the bit clock) go straight to the datapath.

Several registers do not store what was written. A 6-bit level field has no top bit: when that bit is written as 1, the field saturates to 5 ones. A sample rate outside the supported set is replaced by the nearest supported rate, and that replacement is what reads back. The vendor words and the codec-ID word are read-only and are built from two strap inputs: a revision select and the 2-bit codec ID. A write to index 00h returns every register to its default.

Top module: `codec_ctrl_regbank`

## Requirements
- R1: After reset, the main volume (02h) and the second output volume (04h) read 8000h, the front gain (72h) and the rear gain (74h) read 0000h, both rate registers (2Ch DAC, 32h ADC) read 48000 (BB80h), and the 3D register (22h) reads 0000h.
- R2: The level registers 02h, 04h, 72h and 74h use bit 15 as mute, bits 13:8 as the left field and bits 5:0 as the right field. If a field's top bit (bit 13 or bit 5) is written as 1, the field is stored as 11111b. Otherwise its low 5 bits are stored. Bits 14, 13, 7, 6 and 5 always read as 0.
- R3: A write to 2Ch or 32h stores the member of {8000, 11025, 16000, 22050, 32000, 44100, 48000} nearest to the written value. An exact tie goes to the lower rate, and any value above 48000 gives 48000. The stored rate is what reads back.
- R4: Register 22h stores only bits 3:0 as the 3D depth (0 = off, Fh = strongest). All other bits read as 0.
- R5: Index 7Ch reads 574Dh ("WM"). Index 7Eh reads 4C03h ("L" and revision 3) when rev_sel is 0 and 4C04h when rev_sel is 1. Writes to these indices have no effect.
- R6: Index 28h reads the codec_id input in bits 15:14, with all other bits 0, and writes to it have no effect. bitclk_master is 1 exactly when codec_id is 00.
- R7: A write to index 00h restores every writable register to its R1 default at that clock edge. Index 00h reads as 0000h.
- R8: Every index not listed in R1 to R7, including every odd index, reads 0000h, and writes to it change no register.
- R9: The read port shows the register contents before the clock edge. A read of an index in the same cycle as a write to it returns the old value, and the new value appears in the following cycle.
- R10: The outputs vol_mute, vol_left, vol_right (slot 0 = 02h, 1 = 04h, 2 = 72h, 3 = 74h, five bits per slot, slot 0 lowest), depth_3d, dac_rate and adc_rate always equal the stored fields.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| wr_en | input | 1 | Write strobe |
| wr_idx | input | 7 | Write register index |
| wr_data | input | 16 | Write data word |
| rd_idx | input | 7 | Read register index |
| rd_data | output | 16 | Read data word |
| rev_sel | input | 1 | Mode strap selecting vendor revision 3 or 4 |
| codec_id | input | 2 | Codec ID straps |
| vol_mute | output | 4 | Mute bit per level register |
| vol_left | output | 20 | Left level field per level register |
| vol_right | output | 20 | Right level field per level register |
| depth_3d | output | 4 | 3D enhancement depth |
| dac_rate | output | 16 | DAC sample rate in Hz |
| adc_rate | output | 16 | ADC sample rate in Hz |
| bitclk_master | output | 1 | High when this codec drives the bit clock |

## Verification
A register write and a read of the same index can fall in the same cycle. A soft reset through index 00h can also coincide with a read of a rate register. The bench provokes both by raising the write strobe and setting the read index on the same falling edge. It judges the read port twice: once before the rising edge, where it expects the old contents, and once a cycle later, where it expects the saturated, snapped or default value worked out by its own model.

// File: rtl/crb_pkg.sv
package crb_pkg;
  localparam int IDX_W        = 7;
  localparam int DATA_W       = 16;
  localparam int FLD_W        = 5;
  localparam int NUM_VOL      = 4;
  localparam int NUM_RATE_REG = 2;
  localparam int NUM_RATES    = 7;
  localparam int DEPTH_W      = 4;
  localparam int ID_W         = 2;
  localparam int SUM_W        = DATA_W + 2;

  localparam logic [IDX_W-1:0] IDX_SOFT_RST = 7'h00;
  localparam logic [IDX_W-1:0] IDX_DEPTH    = 7'h22;
  localparam logic [IDX_W-1:0] IDX_CODEC_ID = 7'h28;
  localparam logic [IDX_W-1:0] IDX_VEND_HI  = 7'h7C;
  localparam logic [IDX_W-1:0] IDX_VEND_LO  = 7'h7E;

  localparam logic [DATA_W-1:0] VEND_HI_WORD = 16'h574D;
  localparam logic [7:0]        VEND_LO_CHAR = 8'h4C;
  localparam logic [DATA_W-1:0] RATE_DEFAULT = 16'd48000;

  // index of each level register slot
  function automatic logic [IDX_W-1:0] vol_index(input int k);
    case (k)
      0:       return 7'h02;
      1:       return 7'h04;
      2:       return 7'h72;
      default: return 7'h74;
    endcase
  endfunction

  // output volumes start muted, mix gains start open
  function automatic logic [DATA_W-1:0] vol_default(input int k);
    return (k < 2) ? 16'h8000 : 16'h0000;
  endfunction

  function automatic logic [IDX_W-1:0] rate_index(input int k);
    return (k == 0) ? 7'h2C : 7'h32;
  endfunction

  // supported rates in ascending order
  function automatic logic [DATA_W-1:0] rate_at(input int i);
    case (i)
      0:       return 16'd8000;
      1:       return 16'd11025;
      2:       return 16'd16000;
      3:       return 16'd22050;
      4:       return 16'd32000;
      5:       return 16'd44100;
      default: return 16'd48000;
    endcase
  endfunction

  // nearest supported rate; a value exactly midway keeps the lower rate
  function automatic logic [DATA_W-1:0] snap_rate(input logic [DATA_W-1:0] v);
    logic [DATA_W-1:0] r;
    logic [SUM_W-1:0]  twice;
    logic [SUM_W-1:0]  pair_sum;
    r     = rate_at(0);
    twice = {1'b0, v, 1'b0};
    for (int i = 1; i < NUM_RATES; i++) begin
      pair_sum = {2'b00, rate_at(i-1)} + {2'b00, rate_at(i)};
      if (twice > pair_sum) r = rate_at(i);
    end
    return r;
  endfunction
endpackage

// File: rtl/crb_rst_sync.sv
module crb_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [1:0] stage_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stage_q <= 2'b00;
    else        stage_q <= {stage_q[0], 1'b1};
  end

  assign rst_n_sync = stage_q[1];
endmodule

// File: rtl/crb_vol_reg.sv
module crb_vol_reg
  import crb_pkg::*;
#(
  parameter logic [IDX_W-1:0]  REG_IDX  = 7'h02,
  parameter logic [DATA_W-1:0] RST_WORD = 16'h8000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              soft_rst,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic              wr_mute,
  input  logic [FLD_W:0]    wr_left,
  input  logic [FLD_W:0]    wr_right,
  output logic [DATA_W-1:0] rd_word,
  output logic              mute,
  output logic [FLD_W-1:0]  left,
  output logic [FLD_W-1:0]  right
);
  localparam int STATE_W = 1 + 2*FLD_W;
  localparam logic [STATE_W-1:0] RST_STATE =
    {RST_WORD[15], RST_WORD[8 +: FLD_W], RST_WORD[0 +: FLD_W]};

  logic [STATE_W-1:0] state_q, state_d;
  logic               hit;

  // a field whose unsupported top bit is set saturates its lower bits
  function automatic logic [FLD_W-1:0] clip(input logic [FLD_W:0] f);
    return f[FLD_W] ? {FLD_W{1'b1}} : f[FLD_W-1:0];
  endfunction

  assign hit = wr_en && (wr_idx == REG_IDX);

  always_comb begin
    state_d = state_q;
    if (soft_rst)  state_d = RST_STATE;
    else if (hit)  state_d = {wr_mute, clip(wr_left), clip(wr_right)};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= RST_STATE;
    else        state_q <= state_d;
  end

  assign mute    = state_q[STATE_W-1];
  assign left    = state_q[FLD_W +: FLD_W];
  assign right   = state_q[0 +: FLD_W];
  assign rd_word = {mute, 2'b00, left, 3'b000, right};
endmodule

// File: rtl/crb_rate_reg.sv
module crb_rate_reg
  import crb_pkg::*;
#(
  parameter logic [IDX_W-1:0] REG_IDX = 7'h2C
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              soft_rst,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [DATA_W-1:0] wr_data,
  output logic [DATA_W-1:0] rate
);
  logic [DATA_W-1:0] rate_q, rate_d;
  logic              hit;

  assign hit = wr_en && (wr_idx == REG_IDX);

  always_comb begin
    rate_d = rate_q;
    if (soft_rst) rate_d = RATE_DEFAULT;
    else if (hit) rate_d = snap_rate(wr_data);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rate_q <= RATE_DEFAULT;
    else        rate_q <= rate_d;
  end

  assign rate = rate_q;
endmodule

// File: rtl/codec_ctrl_regbank.sv
module codec_ctrl_regbank
  import crb_pkg::*;
(
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     wr_en,
  input  logic [IDX_W-1:0]         wr_idx,
  input  logic [DATA_W-1:0]        wr_data,
  input  logic [IDX_W-1:0]         rd_idx,
  output logic [DATA_W-1:0]        rd_data,
  input  logic                     rev_sel,
  input  logic [ID_W-1:0]          codec_id,
  output logic [NUM_VOL-1:0]       vol_mute,
  output logic [NUM_VOL*FLD_W-1:0] vol_left,
  output logic [NUM_VOL*FLD_W-1:0] vol_right,
  output logic [DEPTH_W-1:0]       depth_3d,
  output logic [DATA_W-1:0]        dac_rate,
  output logic [DATA_W-1:0]        adc_rate,
  output logic                     bitclk_master
);
  logic                    rst_n_int;
  logic                    soft_rst;
  logic [DATA_W-1:0]       vol_rd    [NUM_VOL];
  logic [DATA_W-1:0]       rate_word [NUM_RATE_REG];
  logic [DEPTH_W-1:0]      depth_q, depth_d;
  logic [DATA_W-1:0]       rd_mux;

  crb_rst_sync u_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_int)
  );

  assign soft_rst = wr_en && (wr_idx == IDX_SOFT_RST);

  // level registers: output volumes and mix gains
  for (genvar k = 0; k < NUM_VOL; k++) begin : g_vol
    crb_vol_reg #(
      .REG_IDX  (vol_index(k)),
      .RST_WORD (vol_default(k))
    ) u_vol (
      .clk      (clk),
      .rst_n    (rst_n_int),
      .soft_rst (soft_rst),
      .wr_en    (wr_en),
      .wr_idx   (wr_idx),
      .wr_mute  (wr_data[15]),
      .wr_left  (wr_data[8 +: FLD_W+1]),
      .wr_right (wr_data[0 +: FLD_W+1]),
      .rd_word  (vol_rd[k]),
      .mute     (vol_mute[k]),
      .left     (vol_left[k*FLD_W +: FLD_W]),
      .right    (vol_right[k*FLD_W +: FLD_W])
    );
  end

  // converter rate registers
  for (genvar k = 0; k < NUM_RATE_REG; k++) begin : g_rate
    crb_rate_reg #(
      .REG_IDX (rate_index(k))
    ) u_rate (
      .clk      (clk),
      .rst_n    (rst_n_int),
      .soft_rst (soft_rst),
      .wr_en    (wr_en),
      .wr_idx   (wr_idx),
      .wr_data  (wr_data),
      .rate     (rate_word[k])
    );
  end

  assign dac_rate = rate_word[0];
  assign adc_rate = rate_word[1];

  // 3D depth
  always_comb begin
    depth_d = depth_q;
    if (soft_rst)                               depth_d = '0;
    else if (wr_en && (wr_idx == IDX_DEPTH))    depth_d = wr_data[DEPTH_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n_int) begin
    if (!rst_n_int) depth_q <= '0;
    else            depth_q <= depth_d;
  end

  assign depth_3d      = depth_q;
  assign bitclk_master = (codec_id == '0);

  // read selection, no clock delay
  always_comb begin
    rd_mux = '0;
    for (int k = 0; k < NUM_VOL; k++)
      if (rd_idx == vol_index(k)) rd_mux = vol_rd[k];
    for (int k = 0; k < NUM_RATE_REG; k++)
      if (rd_idx == rate_index(k)) rd_mux = rate_word[k];
    case (rd_idx)
      IDX_DEPTH:    rd_mux = {{(DATA_W-DEPTH_W){1'b0}}, depth_q};
      IDX_CODEC_ID: rd_mux = {codec_id, {(DATA_W-ID_W){1'b0}}};
      IDX_VEND_HI:  rd_mux = VEND_HI_WORD;
      IDX_VEND_LO:  rd_mux = {VEND_LO_CHAR, rev_sel ? 8'h04 : 8'h03};
      default:      ;
    endcase
  end

  assign rd_data = rd_mux;
endmodule

// File: rtl/codec_ctrl_regbank_chk.sv
module codec_ctrl_regbank_chk (
  input logic        clk,
  input logic        rst_ok,
  input logic        wr_en,
  input logic [6:0]  wr_idx,
  input logic        wr_vmsb,
  input logic [3:0]  wr_depth,
  input logic [6:0]  rd_idx,
  input logic [15:0] rd_data,
  input logic [1:0]  codec_id,
  input logic [4:0]  main_left,
  input logic [3:0]  depth_3d,
  input logic [15:0] dac_rate,
  input logic [15:0] adc_rate
);
  // R2
  a_r2_vol_saturates: assert property (@(posedge clk) disable iff (!rst_ok)
    (wr_en && wr_idx == 7'h02 && wr_vmsb) |=> (main_left == 5'h1F));

  // R2
  a_r2_vol_msb_reads_zero: assert property (@(posedge clk) disable iff (!rst_ok)
    (rd_idx == 7'h02 || rd_idx == 7'h04 || rd_idx == 7'h72 || rd_idx == 7'h74)
      |-> (rd_data[13] == 1'b0 && rd_data[5] == 1'b0 && rd_data[14] == 1'b0));

  // R3
  a_r3_dac_rate_supported: assert property (@(posedge clk) disable iff (!rst_ok)
    dac_rate inside {16'd8000, 16'd11025, 16'd16000, 16'd22050, 16'd32000, 16'd44100, 16'd48000});

  // R3
  a_r3_adc_rate_supported: assert property (@(posedge clk) disable iff (!rst_ok)
    adc_rate inside {16'd8000, 16'd11025, 16'd16000, 16'd22050, 16'd32000, 16'd44100, 16'd48000});

  // R4
  a_r4_depth_write: assert property (@(posedge clk) disable iff (!rst_ok)
    (wr_en && wr_idx == 7'h22) |=> (depth_3d == $past(wr_depth)));

  // R5
  a_r5_vendor_hi: assert property (@(posedge clk) disable iff (!rst_ok)
    (rd_idx == 7'h7C) |-> (rd_data == 16'h574D));

  // R6
  a_r6_id_readback: assert property (@(posedge clk) disable iff (!rst_ok)
    (rd_idx == 7'h28) |-> (rd_data == {codec_id, 14'b0}));

  // R7
  a_r7_soft_reset: assert property (@(posedge clk) disable iff (!rst_ok)
    (wr_en && wr_idx == 7'h00)
      |=> (dac_rate == 16'd48000 && adc_rate == 16'd48000 && depth_3d == 4'h0));

  // R8
  a_r8_odd_reads_zero: assert property (@(posedge clk) disable iff (!rst_ok)
    rd_idx[0] |-> (rd_data == 16'h0000));
endmodule

bind codec_ctrl_regbank codec_ctrl_regbank_chk u_chk (
  .clk       (clk),
  .rst_ok    (rst_n_int),
  .wr_en     (wr_en),
  .wr_idx    (wr_idx),
  .wr_vmsb   (wr_data[13]),
  .wr_depth  (wr_data[3:0]),
  .rd_idx    (rd_idx),
  .rd_data   (rd_data),
  .codec_id  (codec_id),
  .main_left (vol_left[4:0]),
  .depth_3d  (depth_3d),
  .dac_rate  (dac_rate),
  .adc_rate  (adc_rate)
);

// File: tb/codec_ctrl_regbank_tb_top.sv
module codec_ctrl_regbank_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG_CYCLES = 190000;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        wr_en;
  logic [6:0]  wr_idx;
  logic [15:0] wr_data;
  logic [6:0]  rd_idx;
  logic [15:0] rd_data;
  logic        rev_sel;
  logic [1:0]  codec_id;
  logic [3:0]  vol_mute;
  logic [19:0] vol_left;
  logic [19:0] vol_right;
  logic [3:0]  depth_3d;
  logic [15:0] dac_rate;
  logic [15:0] adc_rate;
  logic        bitclk_master;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;

  // bench model of the register contents
  logic [15:0] m_vol [4];
  logic [3:0]  m_depth;
  logic [15:0] m_dac, m_adc;

  always #(CLK_PERIOD/2) clk = ~clk;

  codec_ctrl_regbank dut_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
    .rd_idx(rd_idx), .rd_data(rd_data), .rev_sel(rev_sel), .codec_id(codec_id),
    .vol_mute(vol_mute), .vol_left(vol_left), .vol_right(vol_right),
    .depth_3d(depth_3d), .dac_rate(dac_rate), .adc_rate(adc_rate),
    .bitclk_master(bitclk_master)
  );

  function automatic int vol_slot(input logic [6:0] idx);
    case (idx)
      7'h02:   return 0;
      7'h04:   return 1;
      7'h72:   return 2;
      7'h74:   return 3;
      default: return -1;
    endcase
  endfunction

  function automatic logic [15:0] exp_snap(input int v);
    int rates [7] = '{8000, 11025, 16000, 22050, 32000, 44100, 48000};
    int best = rates[0];
    int bd   = (v > best) ? v - best : best - v;
    for (int i = 1; i < 7; i++) begin
      int d = (v > rates[i]) ? v - rates[i] : rates[i] - v;
      if (d < bd) begin bd = d; best = rates[i]; end
    end
    return best[15:0];
  endfunction

  function automatic logic [4:0] sat5(input logic [5:0] f);
    return f[5] ? 5'h1F : f[4:0];
  endfunction

  task automatic model_reset();
    m_vol[0] = 16'h8000; m_vol[1] = 16'h8000;
    m_vol[2] = 16'h0000; m_vol[3] = 16'h0000;
    m_depth  = 4'h0;
    m_dac    = 16'd48000;
    m_adc    = 16'd48000;
  endtask

  task automatic model_write(input logic [6:0] idx, input logic [15:0] d);
    int s = vol_slot(idx);
    if (idx == 7'h00) model_reset();
    else if (s >= 0) m_vol[s] = {d[15], 2'b00, sat5(d[13:8]), 3'b000, sat5(d[5:0])};
    else if (idx == 7'h22) m_depth = d[3:0];
    else if (idx == 7'h2C) m_dac = exp_snap(int'(d));
    else if (idx == 7'h32) m_adc = exp_snap(int'(d));
  endtask

  function automatic logic [15:0] exp_rd(input logic [6:0] idx);
    int s = vol_slot(idx);
    if (s >= 0) return m_vol[s];
    case (idx)
      7'h22:   return {12'h000, m_depth};
      7'h28:   return {codec_id, 14'b0};
      7'h2C:   return m_dac;
      7'h32:   return m_adc;
      7'h7C:   return 16'h574D;
      7'h7E:   return {8'h4C, rev_sel ? 8'h04 : 8'h03};
      default: return 16'h0000;
    endcase
  endfunction

  task automatic check16(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic do_write(input logic [6:0] idx, input logic [15:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_idx = idx; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
    model_write(idx, d);
  endtask

  task automatic read_check(input logic [6:0] idx, input string req);
    @(negedge clk);
    rd_idx = idx;
    #1;
    check16(req, rd_data, exp_rd(idx));
  endtask

  task automatic sweep_all(input string req);
    for (int i = 0; i < 128; i++) read_check(7'(i), req);
  endtask

  task automatic check_outputs(input string req);
    @(negedge clk);
    #1;
    for (int k = 0; k < 4; k++) begin
      check16(req, {15'b0, vol_mute[k]}, {15'b0, m_vol[k][15]});
      check16(req, {11'b0, vol_left[k*5 +: 5]}, {11'b0, m_vol[k][12:8]});
      check16(req, {11'b0, vol_right[k*5 +: 5]}, {11'b0, m_vol[k][4:0]});
    end
    check16(req, {12'b0, depth_3d}, {12'b0, m_depth});
    check16(req, dac_rate, m_dac);
    check16(req, adc_rate, m_adc);
  endtask

  initial begin
    repeat (WATCHDOG_CYCLES) @(posedge clk);
    if (!done) begin
      n_fail++;
      n_checks++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; wr_en = 1'b0; wr_idx = '0; wr_data = '0; rd_idx = '0;
    rev_sel = 1'b0; codec_id = 2'b00;
    model_reset();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 defaults on every index, R10 outputs
    sweep_all("R1");
    check_outputs("R10");

    // R2 every 6-bit field value in each level register, junk in bits 14,7,6
    for (int k = 0; k < 4; k++) begin
      for (int v = 0; v < 64; v++) begin
        logic [5:0] l = 6'(v);
        logic [5:0] r = 6'(63 - v);
        logic [6:0] idx = (k == 0) ? 7'h02 : (k == 1) ? 7'h04 : (k == 2) ? 7'h72 : 7'h74;
        do_write(idx, {l[0], 1'b1, l, 2'b11, r});
        read_check(idx, "R2");
      end
      check_outputs("R10");
    end

    // R4 depth with upper junk
    for (int v = 0; v < 16; v++) begin
      do_write(7'h22, {12'hFA5, 4'(v)});
      read_check(7'h22, "R4");
      check16("R4", {12'b0, depth_3d}, {12'b0, 4'(v)});
    end

    // R3 rate sweep and tie points
    for (int v = 0; v < 65536; v += 13) begin
      do_write(7'h2C, 16'(v));
      read_check(7'h2C, "R3");
    end
    begin
      int corner [14] = '{9512, 9513, 13512, 13513, 19025, 19026, 27025,
                          27026, 38050, 38051, 46050, 46051, 48001, 65535};
      for (int i = 0; i < 14; i++) begin
        do_write(7'h2C, 16'(corner[i]));
        read_check(7'h2C, "R3");
        do_write(7'h32, 16'(corner[13-i]));
        read_check(7'h32, "R3");
      end
    end
    check_outputs("R10");

    // R5 R6 all strap combinations
    for (int id = 0; id < 4; id++) begin
      for (int r = 0; r < 2; r++) begin
        @(negedge clk);
        codec_id = 2'(id); rev_sel = r[0];
        rd_idx = 7'h28; #1; check16("R6", rd_data, {2'(id), 14'b0});
        rd_idx = 7'h7E; #1; check16("R5", rd_data, r[0] ? 16'h4C04 : 16'h4C03);
        rd_idx = 7'h7C; #1; check16("R5", rd_data, 16'h574D);
        check16("R6", {15'b0, bitclk_master}, {15'b0, id == 0});
      end
    end

    // R5 R6 R8 writes to read-only and unimplemented indices
    codec_id = 2'b10; rev_sel = 1'b1;
    for (int i = 1; i < 128; i++) begin
      logic [6:0] idx = 7'(i);
      if (vol_slot(idx) < 0 && idx != 7'h22 && idx != 7'h2C && idx != 7'h32)
        do_write(idx, 16'hFFFF);
    end
    sweep_all("R8");
    check_outputs("R8");

    // R9 read during write of the same index
    @(negedge clk);
    wr_en = 1'b1; wr_idx = 7'h22; wr_data = {12'h000, m_depth ^ 4'hA}; rd_idx = 7'h22;
    #1; check16("R9", rd_data, {12'h000, m_depth});
    @(negedge clk);
    wr_en = 1'b0; model_write(7'h22, wr_data);
    #1; check16("R9", rd_data, {12'h000, m_depth});

    // R7 soft reset after non-default contents, same-cycle read of a rate
    do_write(7'h2C, 16'd11000);
    do_write(7'h04, 16'h3F3F);
    @(negedge clk);
    wr_en = 1'b1; wr_idx = 7'h00; wr_data = 16'h1234; rd_idx = 7'h2C;
    #1; check16("R9", rd_data, 16'd11025);
    @(negedge clk);
    wr_en = 1'b0; model_write(7'h00, 16'h1234);
    #1; check16("R7", rd_data, 16'd48000);
    sweep_all("R7");
    check_outputs("R7");

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
    $finish;
  end
endmodule